// File: doc/BRIEF.md
# Byte-Paced I2C Master Controller

This block is a single-master I2C engine that software drives through three byte-wide registers: a control register, a status register and a data register. Software selects transmit or receive direction and asks for bus conditions (START, repeated START, STOP) through status-register writes. The engine then moves exactly one byte plus its acknowledge bit and parks. It holds SCL low and raises a pending flag until software services the byte by clearing that flag.

The serial clock comes from the system clock through a two-choice prescaler followed by a 4-bit divisor. SCL and SDA are open-drain. The block drives each line low through `scl_low`/`sda_low` and reads the wired line level back on `scl_in`/`sda_in`. A bus monitor watches the lines for START and STOP conditions and keeps a busy flag.

Writes use `reg_we`, `reg_sel` (0 control, 1 status, 2 data) and `reg_wdata`. All three registers are visible at all times on their own read ports.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the control, status and data read ports are all zero, neither line is pulled low, and `irq` is low.
- R2: While a byte is moving, each SCL period lasts P*(D+1) system clocks. D is control bits 3:0. P is 512 when control bit 6 is 1 and 16 when it is 0.
- R3: A status write with bit 4 and bit 5 both set, while the engine is idle, pulls SDA low while SCL is high. It then shifts out the data register, most significant bit first, as the first byte.
- R4: Status bit 5 reads 1 from a START seen on the lines until the next STOP seen on the lines.
- R5: After each byte and its acknowledge bit, control bit 4 (pending) becomes 1, and SCL stays pulled low for as long as it remains 1.
- R6: Writing control bit 4 as 0 clears pending and lets the next action proceed. Writing it as 1 never sets it.
- R7: With status bits 7:6 = 2'b11, bytes after the first go out from the data register. Status bit 0 reads 1 if the receiver left SDA high in the acknowledge slot of the last transmitted byte, and 0 if it pulled SDA low.
- R8: With status bits 7:6 = 2'b10, bytes after the first are shifted in from SDA into the data register. In the acknowledge slot the master pulls SDA low when control bit 7 is 1, and leaves it released when control bit 7 is 0.
- R9: A status write with bits 5 and 4 set while the bus is owned and pending is set produces a repeated START once pending is cleared. No STOP comes in between, and the data register then goes out as an address byte.
- R10: A status write with bit 4 set and bit 5 clear while the bus is owned produces a STOP once pending is cleared: SDA rises while SCL is high and both lines end released.
- R11: `irq` equals pending AND control bit 5.
- R12: Outside START and STOP, SDA changes only while SCL is low, so the lines show exactly one START per requested START and one STOP per requested STOP.
- R13: A status write with bit 4 clear requests no bus condition: no line is pulled and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Register write data |
| ctrl_rd | output | 8 | Control register contents |
| stat_rd | output | 8 | Status register contents |
| data_rd | output | 8 | Data register contents |
| irq | output | 1 | Interrupt output |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_low | output | 1 | Pull SCL low when 1 |
| sda_low | output | 1 | Pull SDA low when 1 |

## Verification
Several properties are checked on every cycle. SCL stays pulled low whenever pending is set. Pending only drops through a control write that clears it. Data-phase SDA moves only inside the SCL-low window. Busy rises only with SDA low under a high SCL. Clock ticks never come back to back. The bench scenarios, driven against a behavioural target device, are what show the byte values, MSB-first order, acknowledge polarity in both directions, the exact SCL period for each prescale and divisor setting, and the absence of a STOP across a repeated START.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int DIV_W = 4;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam logic [1:0] MODE_TX = 2'b11;
  localparam logic [1:0] MODE_RX = 2'b10;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_BIT, E_HOLD, E_STOP
  } eng_state_t;

  typedef enum logic [1:0] {
    C_NONE, C_START, C_STOP
  } cmd_t;
endpackage

// File: rtl/i2cm_clkgen.sv
module i2cm_clkgen import i2cm_pkg::*; #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int QLO = PRE_LO / 4;
  localparam int QHI = PRE_HI / 4;
  localparam int CW  = $clog2(QHI);
  localparam logic [CW-1:0] LIM_LO = CW'(QLO - 1);
  localparam logic [CW-1:0] LIM_HI = CW'(QHI - 1);

  logic [CW-1:0]    pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CW-1:0]    lim;
  logic             pre_wrap;

  assign lim      = pre_sel ? LIM_HI : LIM_LO;
  assign pre_wrap = (pre_q >= lim);
  assign tick     = run && pre_wrap && (div_q >= div);

  always_comb begin
    pre_d = pre_q;
    div_d = div_q;
    if (!run) begin
      pre_d = '0;
      div_d = '0;
    end else if (pre_wrap) begin
      pre_d = '0;
      div_d = (div_q >= div) ? '0 : div_q + 1'b1;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end

  // R2: quarter-phase ticks are separated by at least one idle cycle
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic busy
);
  logic scl_q, sda_q, busy_q, busy_d;
  logic start_seen, stop_seen;

  assign start_seen = scl_q && scl_in && sda_q && !sda_in;
  assign stop_seen  = scl_q && scl_in && !sda_q && sda_in;
  assign busy       = busy_q;

  always_comb begin
    busy_d = busy_q;
    if (start_seen)     busy_d = 1'b1;
    else if (stop_seen) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q  <= scl_in;
      sda_q  <= sda_in;
      busy_q <= busy_d;
    end
  end

  // R4: busy only rises while SDA is held low under a high SCL
  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (scl_in && !sda_in));
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  cmd_t       cmd,
  input  logic       pend,
  input  logic       tx_mode,
  input  logic       ack_en,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       run,
  output logic       owned,
  output logic       scl_low,
  output logic       sda_low,
  output logic       byte_done,
  output logic       byte_tx,
  output logic [7:0] rx_byte,
  output logic       ack_bit,
  output logic       cmd_take
);
  eng_state_t st_q, st_d;
  logic [1:0] ph_q, ph_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       tx_q, tx_d, scl_q, scl_d, sda_q, sda_d, ak_q, ak_d;
  logic       ack_slot;

  assign ack_slot = bit_q[3];
  assign run      = (st_q == E_START) || (st_q == E_BIT) || (st_q == E_STOP);
  assign owned    = (st_q != E_IDLE);
  assign scl_low  = scl_q;
  assign sda_low  = sda_q;
  assign byte_tx  = tx_q;
  assign rx_byte  = sh_q;
  assign ack_bit  = ak_q;

  always_comb begin
    st_d = st_q;  ph_d = ph_q;  bit_d = bit_q;  sh_d = sh_q;
    tx_d = tx_q;  scl_d = scl_q; sda_d = sda_q; ak_d = ak_q;
    byte_done = 1'b0;
    cmd_take  = 1'b0;
    unique case (st_q)
      E_IDLE: begin
        scl_d = 1'b0;
        sda_d = 1'b0;
        if (cmd == C_START) begin
          st_d = E_START; ph_d = 2'd0; cmd_take = 1'b1;
        end
      end
      E_START: if (tick) begin
        ph_d = ph_q + 2'd1;
        unique case (ph_q)
          2'd0: sda_d = 1'b0;
          2'd1: scl_d = 1'b0;
          2'd2: sda_d = 1'b1;
          default: begin
            scl_d = 1'b1; st_d = E_BIT; bit_d = 4'd0;
            sh_d = tx_byte; tx_d = 1'b1;
          end
        endcase
      end
      E_BIT: if (tick) begin
        ph_d = ph_q + 2'd1;
        unique case (ph_q)
          2'd0: sda_d = ack_slot ? (!tx_q && ack_en) : (tx_q && !sh_q[7]);
          2'd1: scl_d = 1'b0;
          2'd2: begin
            if (!ack_slot && !tx_q) sh_d = {sh_q[6:0], sda_in};
            if (ack_slot && tx_q)   ak_d = sda_in;
          end
          default: begin
            scl_d = 1'b1;
            if (tx_q && !ack_slot) sh_d = {sh_q[6:0], 1'b0};
            if (ack_slot) begin
              st_d = E_HOLD; byte_done = 1'b1;
            end else begin
              bit_d = bit_q + 4'd1;
            end
          end
        endcase
      end
      E_HOLD: if (!pend) begin
        ph_d = 2'd0;
        if (cmd == C_STOP) begin
          st_d = E_STOP; cmd_take = 1'b1;
        end else if (cmd == C_START) begin
          st_d = E_START; cmd_take = 1'b1;
        end else begin
          st_d = E_BIT; bit_d = 4'd0; tx_d = tx_mode;
          sh_d = tx_mode ? tx_byte : 8'h00;
        end
      end
      default: if (tick) begin
        ph_d = ph_q + 2'd1;
        unique case (ph_q)
          2'd0: sda_d = 1'b1;
          2'd1: scl_d = 1'b0;
          default: begin
            sda_d = 1'b0; st_d = E_IDLE;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= E_IDLE; ph_q <= '0; bit_q <= '0; sh_q <= '0;
      tx_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0; ak_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bit_q <= bit_d; sh_q <= sh_d;
      tx_q <= tx_d; scl_q <= scl_d; sda_q <= sda_d; ak_q <= ak_d;
    end
  end

  // R12: during data and acknowledge bits SDA moves only inside the SCL-low window
  p_sda_in_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_BIT && $past(st_q) == E_BIT && sda_q != $past(sda_q))
      |-> (scl_q && $past(scl_q)));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master import i2cm_pkg::*; #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ctrl_rd,
  output logic [7:0] stat_rd,
  output logic [7:0] data_rd,
  output logic       irq,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low
);
  logic             ack_en_q, ack_en_d, pre_q, pre_d, ien_q, ien_d, pend_q, pend_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [1:0]       mode_q, mode_d;
  logic             en_q, en_d, nack_q, nack_d;
  logic [7:0]       data_q, data_d;
  cmd_t             cmd_q, cmd_d;

  logic       wr_ctrl, wr_stat, wr_data;
  logic       tick, run, owned, byte_done, byte_tx, ack_bit, cmd_take, busy;
  logic [7:0] rx_byte;

  assign wr_ctrl = reg_we && (reg_sel == SEL_CTRL);
  assign wr_stat = reg_we && (reg_sel == SEL_STAT);
  assign wr_data = reg_we && (reg_sel == SEL_DATA);

  i2cm_clkgen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_q), .div(div_q), .tick(tick));

  i2cm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd(cmd_q), .pend(pend_q),
    .tx_mode(mode_q == MODE_TX), .ack_en(ack_en_q), .tx_byte(data_q), .sda_in(sda_in),
    .run(run), .owned(owned), .scl_low(scl_low), .sda_low(sda_low),
    .byte_done(byte_done), .byte_tx(byte_tx), .rx_byte(rx_byte), .ack_bit(ack_bit),
    .cmd_take(cmd_take));

  i2cm_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .busy(busy));

  always_comb begin
    ack_en_d = ack_en_q; pre_d = pre_q; ien_d = ien_q; div_d = div_q; pend_d = pend_q;
    mode_d = mode_q; en_d = en_q; nack_d = nack_q; data_d = data_q; cmd_d = cmd_q;
    if (wr_ctrl) begin
      ack_en_d = reg_wdata[7];
      pre_d    = reg_wdata[6];
      ien_d    = reg_wdata[5];
      div_d    = reg_wdata[DIV_W-1:0];
      if (!reg_wdata[4]) pend_d = 1'b0;
    end
    if (byte_done) pend_d = 1'b1;
    if (cmd_take) cmd_d = C_NONE;
    if (wr_stat) begin
      mode_d = reg_wdata[7:6];
      en_d   = reg_wdata[4];
      if (reg_wdata[4]) begin
        if (reg_wdata[5])  cmd_d = C_START;
        else if (owned)    cmd_d = C_STOP;
        else               cmd_d = C_NONE;
      end
    end
    if (wr_data) data_d = reg_wdata;
    if (byte_done && !byte_tx) data_d = rx_byte;
    if (byte_done && byte_tx)  nack_d = ack_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en_q <= 1'b0; pre_q <= 1'b0; ien_q <= 1'b0; pend_q <= 1'b0; div_q <= '0;
      mode_q <= 2'b00; en_q <= 1'b0; nack_q <= 1'b0; data_q <= '0; cmd_q <= C_NONE;
    end else begin
      ack_en_q <= ack_en_d; pre_q <= pre_d; ien_q <= ien_d; pend_q <= pend_d; div_q <= div_d;
      mode_q <= mode_d; en_q <= en_d; nack_q <= nack_d; data_q <= data_d; cmd_q <= cmd_d;
    end
  end

  assign ctrl_rd = {ack_en_q, pre_q, ien_q, pend_q, div_q};
  assign stat_rd = {mode_q, busy, en_q, 3'b000, nack_q};
  assign data_rd = data_q;
  assign irq     = pend_q && ien_q;

  // R5: the bus is stretched for the whole time a byte awaits service
  p_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> scl_low);

  // R6: pending only drops through a control write that clears it
  p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(wr_ctrl && !reg_wdata[4])) |=> pend_q);
endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [1:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [7:0] ctrl_rd, stat_rd, data_rd;
  logic       irq, scl_low, sda_low, slv_low;
  logic       scl_line, sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign scl_line = ~scl_low;
  assign sda_line = ~(sda_low | slv_low);

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_rd(ctrl_rd), .stat_rd(stat_rd), .data_rd(data_rd), .irq(irq),
    .scl_in(scl_line), .sda_in(sda_line), .scl_low(scl_low), .sda_low(sda_low));

  // ---------------- behavioural target device ----------------
  logic       prev_scl = 1'b1, prev_sda = 1'b1;
  int         pos = 15, byte_idx = 0, rx_cnt = 0, mack_cnt = 0;
  int         start_cnt = 0, stop_cnt = 0;
  bit         rd = 0, quiet = 1;
  logic       slv_ack_data = 1'b1;
  logic [7:0] shr = 8'h00;
  logic [7:0] rx_log [0:63];
  logic       mack_log [0:63];
  logic [7:0] rd_bytes [0:3];

  initial slv_low = 1'b0;

  always @(posedge clk) begin
    if (prev_scl && scl_line && prev_sda && !sda_line) begin
      start_cnt++; pos = 15; byte_idx = 0; rd = 0; quiet = 0; slv_low <= 1'b0;
    end else if (prev_scl && scl_line && !prev_sda && sda_line) begin
      stop_cnt++; pos = 15; quiet = 1; slv_low <= 1'b0;
    end else if (!quiet && prev_scl && !scl_line) begin
      if (pos == 15) pos = 0;
      else if (pos == 8) begin pos = 0; byte_idx++; end
      else pos++;
      if (pos == 8 && (byte_idx == 0 || !rd))
        slv_low <= (byte_idx == 0) ? 1'b1 : slv_ack_data;
      else if (pos < 8 && rd && byte_idx > 0)
        slv_low <= ~rd_bytes[(byte_idx - 1) % 4][7 - pos];
      else
        slv_low <= 1'b0;
    end else if (!quiet && !prev_scl && scl_line) begin
      if (pos < 8) shr = {shr[6:0], sda_line};
      if (pos == 7) begin
        if (byte_idx == 0) rd = shr[0];
        if (byte_idx == 0 || !rd) begin rx_log[rx_cnt % 64] = shr; rx_cnt++; end
      end
      if (pos == 8 && rd && byte_idx > 0) begin
        mack_log[mack_cnt % 64] = sda_line; mack_cnt++;
        if (sda_line) quiet = 1;
      end
    end
    prev_scl <= scl_line;
    prev_sda <= sda_line;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_pend;
    while (ctrl_rd[4] !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_free;
    while (stat_rd[5] !== 1'b0) @(negedge clk);
  endtask

  task automatic meas(output int p);
    int n = 0;
    while (scl_low !== 1'b0) @(negedge clk);
    while (scl_low !== 1'b1) begin @(negedge clk); n++; end
    while (scl_low !== 1'b0) begin @(negedge clk); n++; end
    p = n;
  endtask

  // {address, data, target acks data, prescale select, divisor}
  localparam logic [21:0] VECS [0:4] = '{
    {8'hA0, 8'h5A, 1'b1, 1'b0, 4'd0},
    {8'h42, 8'hC3, 1'b0, 1'b0, 4'd1},
    {8'h7E, 8'h01, 1'b1, 1'b0, 4'd2},
    {8'h10, 8'hFF, 1'b0, 1'b0, 4'd0},
    {8'hB4, 8'h69, 1'b1, 1'b1, 4'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ctrl", ctrl_rd, 8'h00);
    chk("R1 stat", stat_rd, 8'h00);
    chk("R1 data", data_rd, 8'h00);
    chk("R1 lines", {scl_low, sda_low}, 2'b00);
    chk("R1 irq", irq, 1'b0);

    // R6: writing pending as 1 never sets it
    wr(2'd0, 8'h10);
    chk("R6 set ignored", ctrl_rd[4], 1'b0);

    // R13: status write with enable clear requests nothing
    wr(2'd1, 8'hE0);
    repeat (300) @(negedge clk);
    chk("R13 no start", start_cnt, 0);
    chk("R13 sda idle", sda_low, 1'b0);
    chk("R13 not busy", stat_rd[5], 1'b0);

    // vector loop: one address byte and one data byte in transmit mode
    for (int i = 0; i < 5; i++) begin
      logic [7:0] va, vd;
      logic       vk, vp;
      logic [3:0] vv;
      logic [7:0] cw;
      int         per, stops0;
      bit         held;
      {va, vd, vk, vp, vv} = VECS[i];
      cw = {1'b0, vp, 1'b1, 1'b0, vv};
      slv_ack_data = vk;
      wr(2'd0, cw);
      wr(2'd2, va);
      wr(2'd1, 8'hF0);
      wait_pend();
      chk("R4 busy after start", stat_rd[5], 1'b1);
      chk("R7 address acked", stat_rd[0], 1'b0);
      chk("R3 address byte", rx_log[(rx_cnt - 1) % 64], va);
      chk("R11 irq with pending", irq, 1'b1);
      held = 1;
      for (int k = 0; k < 50; k++) begin
        @(negedge clk);
        if (scl_low !== 1'b1) held = 0;
      end
      chk("R5 scl stretched", held, 1'b1);
      wr(2'd2, vd);
      wr(2'd0, cw);
      chk("R11 irq cleared", irq, 1'b0);
      meas(per);
      chk("R2 scl period", per, (vp ? 512 : 16) * (int'(vv) + 1));
      wait_pend();
      chk("R7 nack flag", stat_rd[0], !vk);
      chk("R7 data byte", rx_log[(rx_cnt - 1) % 64], vd);
      stops0 = stop_cnt;
      wr(2'd1, 8'hD0);
      wr(2'd0, cw);
      wait_free();
      chk("R10 stop seen", stop_cnt, stops0 + 1);
      chk("R10 lines released", {scl_low, sda_low}, 2'b00);
    end

    // R8: receive two bytes, ACK then NACK
    rd_bytes[0] = 8'h96; rd_bytes[1] = 8'h3C;
    wr(2'd0, 8'hA0);
    wr(2'd2, 8'hA1);
    wr(2'd1, 8'hB0);
    wait_pend();
    chk("R7 read address acked", stat_rd[0], 1'b0);
    wr(2'd0, 8'hA0);
    wait_pend();
    chk("R8 first byte", data_rd, 8'h96);
    wr(2'd0, 8'h20);
    wait_pend();
    chk("R8 second byte", data_rd, 8'h3C);
    chk("R8 master ack", mack_log[(mack_cnt - 2) % 64], 1'b0);
    chk("R8 master nack", mack_log[(mack_cnt - 1) % 64], 1'b1);
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h20);
    wait_free();
    chk("R10 stop after read", {scl_low, sda_low}, 2'b00);

    // R9: write byte, then repeated START into a read
    begin
      int s0, p0;
      bit held;
      slv_ack_data = 1'b1;
      rd_bytes[0] = 8'h5C;
      wr(2'd0, 8'h20);
      wr(2'd2, 8'hA0);
      wr(2'd1, 8'hF0);
      wait_pend();
      wr(2'd2, 8'h11);
      wr(2'd0, 8'h20);
      wait_pend();
      chk("R7 restart data byte", rx_log[(rx_cnt - 1) % 64], 8'h11);
      wr(2'd0, 8'h30);
      held = 1;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (scl_low !== 1'b1 || ctrl_rd[4] !== 1'b1) held = 0;
      end
      chk("R6 pending kept by write of one", held, 1'b1);
      s0 = start_cnt; p0 = stop_cnt;
      wr(2'd2, 8'hA1);
      wr(2'd1, 8'hB0);
      wr(2'd0, 8'h20);
      wait_pend();
      chk("R9 extra start", start_cnt, s0 + 1);
      chk("R9 no stop between", stop_cnt, p0);
      chk("R9 address after restart", rx_log[(rx_cnt - 1) % 64], 8'hA1);
      chk("R4 still busy", stat_rd[5], 1'b1);
      wr(2'd0, 8'h20);
      wait_pend();
      chk("R8 byte after restart", data_rd, 8'h5C);
      chk("R8 nack final", mack_log[(mack_cnt - 1) % 64], 1'b1);
      wr(2'd1, 8'h90);
      wr(2'd0, 8'h20);
      wait_free();
      chk("R4 busy cleared", stat_rd[5], 1'b0);
    end

    // R12: exactly the requested bus conditions appeared
    chk("R12 start count", start_cnt, 8);
    chk("R12 stop count", stop_cnt, 7);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule